// File: doc/BRIEF.md
# Two-Input Four-State Lamp Sequencer

This block is a Moore state machine that walks among four states, S0, S1, S2 and S3, under the control of two single-bit steering inputs, `sel_a` and `sel_b`. The state is held in a 2-bit binary register. Some states look at both inputs. Others look at only one of them.

Each state owns one lamp. Lamp n is lit while the machine sits in state Sn. The lamps come from their own register stage, so a lamp lights one rising edge after its state is entered. Reset is synchronous and active high. It forces the state to S0 and turns every lamp off. The encoded state is brought out as well, so the walk can be observed.

The named transitions are:
- S0_STAY: S0 to S0.
- S0_TO_S2: S0 to S2.
- S1_STAY: S1 to S1.
- S1_TO_S3: S1 to S3.
- S1_TO_S0: S1 to S0.
- S2_TO_S1: S2 to S1.
- S2_TO_S3: S2 to S3.
- S3_STAY: S3 to S3.
- S3_TO_S1: S3 to S1.
- S3_TO_S0: S3 to S0.

Top module: `lamp_fsm`

## Requirements
- R1: While `rst` is sampled 1 at a rising edge, the state becomes S0 (`state_o` = 2'b00) and all four lamp bits become 0 at that edge.
- R2: In S0 the next state is S2 when `sel_a` = 1, whatever `sel_b` is (S0_TO_S2). When `sel_a` = 0 the state stays S0 (S0_STAY).
- R3: In S2 only `sel_b` is examined. `sel_b` = 0 goes to S1 (S2_TO_S1), and `sel_b` = 1 goes to S3 (S2_TO_S3).
- R4: In S1, `sel_b` = 0 returns to S0 (S1_TO_S0). (`sel_a`,`sel_b`) = (1,1) goes to S3 (S1_TO_S3). (0,1) stays in S1 (S1_STAY).
- R5: In S3, `sel_b` = 0 returns to S0 (S3_TO_S0). (1,1) stays in S3 (S3_STAY). (0,1) goes to S1 (S3_TO_S1).
- R6: Outside reset, `lamp_o[n]` after a rising edge is 1 exactly when the state held before that edge was Sn. Lamps therefore trail the state by one edge.
- R7: At the first rising edge with `rst` = 0 after reset, `lamp_o` becomes 4'b0001 (lamp 0 on).
- R8: After that first edge, and for as long as reset stays low, exactly one lamp bit is 1.
- R9: `state_o` carries the binary code of the state: S0 = 2'b00, S1 = 2'b01, S2 = 2'b10, S3 = 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_a | input | 1 | First steering input |
| sel_b | input | 1 | Second steering input |
| lamp_o | output | 4 | Registered lamp outputs; bit n belongs to state Sn |
| state_o | output | 2 | Encoded current state |

## Verification
S3_STAY and S3_TO_S1 are the hardest paths to reach from the ports. S3 can only be entered through S2 or S1 with `sel_b` held high. Once there, any cycle with `sel_b` low drops the machine back to S0, so a uniform random walk spends little time in S3 with varied `sel_a`. The stimulus therefore walks S0→S2→S3 by directed steps and then exercises both S3 exits. The random phase draws `sel_b` = 1 three times out of four, which keeps the machine cycling among S1, S2 and S3 instead of falling back to S0.

// File: rtl/lamp_fsm_pkg.sv
package lamp_fsm_pkg;
    parameter int unsigned NUM_ST = 4;
    localparam int unsigned ST_W  = $clog2(NUM_ST);

    typedef enum logic [ST_W-1:0] {
        ST_S0 = 2'b00,
        ST_S1 = 2'b01,
        ST_S2 = 2'b10,
        ST_S3 = 2'b11
    } state_t;
endpackage

// File: rtl/lamp_fsm_next.sv
module lamp_fsm_next
    import lamp_fsm_pkg::*;
(
    input  state_t cur_st,
    input  logic   sel_a,
    input  logic   sel_b,
    output state_t nxt_st
);
    always_comb begin
        nxt_st = cur_st;
        unique case (cur_st)
            ST_S0: nxt_st = sel_a ? ST_S2 : ST_S0;              // S0_TO_S2 / S0_STAY
            ST_S1: begin
                if (!sel_b)     nxt_st = ST_S0;                 // S1_TO_S0
                else if (sel_a) nxt_st = ST_S3;                 // S1_TO_S3
                else            nxt_st = ST_S1;                 // S1_STAY
            end
            ST_S2: nxt_st = sel_b ? ST_S3 : ST_S1;              // S2_TO_S3 / S2_TO_S1
            ST_S3: begin
                if (!sel_b)     nxt_st = ST_S0;                 // S3_TO_S0
                else if (sel_a) nxt_st = ST_S3;                 // S3_STAY
                else            nxt_st = ST_S1;                 // S3_TO_S1
            end
            default: nxt_st = ST_S0;
        endcase
    end
endmodule

// File: rtl/lamp_fsm_state_reg.sv
module lamp_fsm_state_reg
    import lamp_fsm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  state_t nxt_st,
    output state_t cur_st
);
    always_ff @(posedge clk) begin
        if (rst) cur_st <= ST_S0;
        else     cur_st <= nxt_st;
    end
endmodule

// File: rtl/lamp_fsm_lamp_reg.sv
module lamp_fsm_lamp_reg
    import lamp_fsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  state_t            cur_st,
    output logic [NUM_ST-1:0] lamp_q
);
    for (genvar g = 0; g < NUM_ST; g++) begin : g_lamp
        always_ff @(posedge clk) begin
            if (rst) lamp_q[g] <= 1'b0;
            else     lamp_q[g] <= (cur_st == state_t'(g));
        end
    end
endmodule

// File: rtl/lamp_fsm.sv
module lamp_fsm
    import lamp_fsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_a,
    input  logic              sel_b,
    output logic [NUM_ST-1:0] lamp_o,
    output logic [ST_W-1:0]   state_o
);
    state_t cur_st;
    state_t nxt_st;

    lamp_fsm_next u_next (
        .cur_st (cur_st),
        .sel_a  (sel_a),
        .sel_b  (sel_b),
        .nxt_st (nxt_st)
    );

    lamp_fsm_state_reg u_state (
        .clk    (clk),
        .rst    (rst),
        .nxt_st (nxt_st),
        .cur_st (cur_st)
    );

    lamp_fsm_lamp_reg u_lamp (
        .clk    (clk),
        .rst    (rst),
        .cur_st (cur_st),
        .lamp_q (lamp_o)
    );

    assign state_o = cur_st;
endmodule

// File: rtl/lamp_fsm_chk.sv
module lamp_fsm_chk
    import lamp_fsm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sel_a,
    input logic              sel_b,
    input logic [NUM_ST-1:0] lamp_o,
    input logic [ST_W-1:0]   state_o
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (state_o == 2'b00 && lamp_o == '0));

    assert_s0_step_R2: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b00) |=> (state_o == ($past(sel_a) ? 2'b10 : 2'b00)));

    assert_s2_step_R3: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b10) |=> (state_o == ($past(sel_b) ? 2'b11 : 2'b01)));

    assert_s1_step_R4: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b01) |=>
            (state_o == (!$past(sel_b) ? 2'b00 : ($past(sel_a) ? 2'b11 : 2'b01))));

    assert_s3_step_R5: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b11) |=>
            (state_o == (!$past(sel_b) ? 2'b00 : ($past(sel_a) ? 2'b11 : 2'b01))));

    assert_lamp_trails_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (lamp_o == (NUM_ST'(1) << $past(state_o))));

    assert_first_lamp_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |=> (lamp_o == NUM_ST'(1)));

    assert_lamp_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($countones(lamp_o) == 1));
endmodule

bind lamp_fsm lamp_fsm_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .sel_a   (sel_a),
    .sel_b   (sel_b),
    .lamp_o  (lamp_o),
    .state_o (state_o)
);

// File: tb/lamp_fsm_tb_top.sv
module lamp_fsm_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_a = 1'b0;
    logic       sel_b = 1'b0;
    logic [3:0] lamp_o;
    logic [1:0] state_o;

    int n_checks = 0;
    int n_errors = 0;
    logic [1:0] exp_st = 2'b00;
    logic [3:0] exp_lamp = 4'b0000;
    bit         first_after_rst = 1'b0;

    always #10 clk = ~clk;

    lamp_fsm dut_i (
        .clk     (clk),
        .rst     (rst),
        .sel_a   (sel_a),
        .sel_b   (sel_b),
        .lamp_o  (lamp_o),
        .state_o (state_o)
    );

    function automatic logic [1:0] ref_next(input logic [1:0] s, input logic a, input logic b);
        case (s)
            2'b00:   return a ? 2'b10 : 2'b00;
            2'b10:   return b ? 2'b11 : 2'b01;
            default: return !b ? 2'b00 : (a ? 2'b11 : 2'b01);
        endcase
    endfunction

    function automatic string st_req(input logic [1:0] s);
        case (s)
            2'b00:   return "R2";
            2'b10:   return "R3";
            2'b01:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // drive inputs, take one edge, then compare against the model
    task automatic step(input logic r, input logic a, input logic b);
        string tag;
        logic  was_rst;
        rst = r; sel_a = a; sel_b = b;
        was_rst = rst;
        tag = st_req(exp_st);
        @(posedge clk);
        first_after_rst = !r && (exp_lamp == 4'b0000);
        if (r) begin
            exp_lamp = 4'b0000;
            exp_st   = 2'b00;
        end else begin
            exp_lamp = 4'b0001 << exp_st;
            exp_st   = ref_next(exp_st, a, b);
        end
        #5;
        if (was_rst) begin
            check("R1", {2'b00, state_o}, {2'b00, exp_st});
            check("R1", lamp_o, exp_lamp);
        end else begin
            check(tag, {2'b00, state_o}, {2'b00, exp_st});
            check("R6", lamp_o, exp_lamp);
            check("R8", {3'b000, ($countones(lamp_o) == 1)}, 4'b0001);
            if (first_after_rst) check("R7", lamp_o, 4'b0001);
        end
    endtask

    initial begin : watchdog
        #2000000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : stim
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        #5;
        step(1, 1, 1);
        step(1, 0, 1);
        // R7: first edge out of reset lights lamp 0
        step(0, 0, 0);            // S0_STAY
        step(0, 0, 1);            // S0_STAY with sel_b high
        step(0, 1, 0);            // S0_TO_S2 (R2)
        check("R9", {2'b00, state_o}, 4'b0010);
        step(0, 1, 1);            // S2_TO_S3 (R3)
        check("R9", {2'b00, state_o}, 4'b0011);
        step(0, 1, 1);            // S3_STAY (R5)
        step(0, 0, 1);            // S3_TO_S1 (R5)
        check("R9", {2'b00, state_o}, 4'b0001);
        step(0, 0, 1);            // S1_STAY (R4)
        step(0, 1, 1);            // S1_TO_S3 (R4)
        step(0, 1, 0);            // S3_TO_S0 (R5)
        check("R9", {2'b00, state_o}, 4'b0000);
        step(0, 1, 1);            // S0_TO_S2, sel_b ignored (R2)
        step(0, 1, 0);            // S2_TO_S1, sel_a ignored (R3)
        step(0, 1, 0);            // S1_TO_S0 (R4)
        step(0, 1, 0);            // S0_TO_S2
        step(0, 0, 1);            // S2_TO_S3
        step(0, 0, 0);            // S3_TO_S0
        // reset in mid-walk (R1)
        step(0, 1, 1);
        step(1, 1, 1);
        step(0, 1, 1);
        for (int i = 0; i < 600; i++) begin
            logic ra, rb, rr;
            ra = $urandom_range(0, 1);
            rb = ($urandom_range(0, 3) != 0);
            rr = ($urandom_range(0, 99) == 0);
            step(rr, ra, rb);
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule